// File: doc/BRIEF.md
# Interrupt Status Aggregator with Level and Pulse Outputs

This block collects single-cycle strobes from four event sources (key event, long key, timeout, missed event) into a sticky raw status vector. A separate enable vector masks that raw vector into a pending view. The block drives two interrupt lines from the pending view. One is a level line that stays high while anything enabled is pending. The other is a pulse line that fires once and then waits for a software end-of-interrupt write before it can fire again.

Software reaches the block through a simple register port. Each write carries a strobe, a word address and data. Read data always reflects the addressed register, with no wait cycle. The raw view lets software inject events for test. Pending events are acknowledged by writing ones to the pending view, and that write clears the underlying raw bit. Enables are changed only through a set address and a clear address, so no read-modify-write is needed.

Bit positions are the same in every view: bit 0 key event, bit 1 long key, bit 2 timeout, bit 3 missed event. Word addresses are: 0 raw view, 1 pending view, 2 enable-set, 3 enable-clear, 4 end-of-interrupt. Unused data bits read 0.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset, the raw vector and the enable vector are zero, both interrupt outputs are low, and the pulse logic is armed.
- R2: A strobe on `evt_i[k]` sets raw bit k on the next clock edge, whether or not source k is enabled.
- R3: A write to address 0 sets every raw bit whose data bit is 1. Data bits that are 0 leave their raw bits unchanged.
- R4: Reading address 1 returns, for each source k, raw bit k AND enable bit k.
- R5: A write to address 1 clears every raw bit whose data bit is 1, including bits of sources that are not enabled.
- R6: If an event strobe and a clear through address 1 hit the same bit in the same cycle, the bit stays set.
- R7: Reads at address 2 and at address 3 both return the 3-bit enable vector. Writing 1 to a bit at address 2 sets that enable. Writing 1 at address 3 clears it. Writing 0 at either address changes nothing.
- R8: `irq_level` is high exactly when at least one bit of the pending view (address 1) is set.
- R9: When the pulse logic is armed and the pending view becomes non-empty, `irq_pulse` is high for exactly one cycle, starting on the clock edge after the pending view first became non-empty. Firing disarms the logic.
- R10: Once disarmed, the pulse logic emits no further pulse until a write to address 4. That write re-arms it, and a pulse follows one cycle later if any enabled event is still pending.
- R11: The missed-event source (bit 3) has no enable bit. It always reads 0 in the pending view and never drives either interrupt line. Writing to bit 3 at address 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address of the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_i | input | 4 | One-cycle event strobes, one per source |
| irq_level | output | 1 | Level interrupt line |
| irq_pulse | output | 1 | One-cycle pulsed interrupt line |

## Verification
The bench uses the default parameters: four sources, three of which have enables, so the source without an enable lies inside the tested range. With this split the bench can show that the top source is masked from the pending view and from both lines, and that an enable-set write to bit 3 changes nothing. Three enables make it possible to have pending bits that are enabled and pending bits that are not at the same time. That lets the bench check that clearing through the pending view also clears a bit that is not enabled. It also checks that an event colliding with a clear leaves the bit set, and that a write to address 4 is the only thing that re-arms the pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned REG_ADDR_W = 3;
    localparam int unsigned REG_DATA_W = 32;
    localparam int unsigned SRC_COUNT  = 4;
    localparam int unsigned EN_COUNT   = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_RAW    = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_EN_SET = 3'd2,
        SEL_EN_CLR = 3'd3,
        SEL_EOI    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic raw_set;
        logic pend_clr;
        logic en_set;
        logic en_clr;
        logic eoi;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic wr, input logic [REG_ADDR_W-1:0] addr);
        wr_dec_t d;
        d.raw_set  = wr && (addr == SEL_RAW);
        d.pend_clr = wr && (addr == SEL_PEND);
        d.en_set   = wr && (addr == SEL_EN_SET);
        d.en_clr   = wr && (addr == SEL_EN_CLR);
        d.eoi      = wr && (addr == SEL_EOI);
        return d;
    endfunction

endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] raw_o
);

    logic [N_SRC-1:0] raw_q;

    for (genvar k = 0; k < N_SRC; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[k] <= 1'b0;
            end else if (evt_i[k] || set_i[k]) begin
                raw_q[k] <= 1'b1;
            end else if (clr_i[k]) begin
                raw_q[k] <= 1'b0;
            end
        end

        // Event sets the bit, and beats a same-cycle clear
        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
            evt_i[k] |=> raw_q[k]);
        assert_evt_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (evt_i[k] && clr_i[k]) |=> raw_q[k]);
        assert_sw_set_R3: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> raw_q[k]);
        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !evt_i[k] && !set_i[k]) |=> !raw_q[k]);
        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[k] && !evt_i[k] && !set_i[k]) |=> $stable(raw_q[k]));
    end

    assign raw_o = raw_q;

endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
    parameter int unsigned N_EN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_EN-1:0] set_i,
    input  logic [N_EN-1:0] clr_i,
    output logic [N_EN-1:0] en_o
);

    logic [N_EN-1:0] en_q;

    for (genvar k = 0; k < N_EN; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[k] <= 1'b0;
            end else if (set_i[k]) begin
                en_q[k] <= 1'b1;
            end else if (clr_i[k]) begin
                en_q[k] <= 1'b0;
            end
        end

        assert_en_set_R7: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> en_q[k]);
        assert_en_clr_R7: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !en_q[k]);
        assert_en_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[k] && !set_i[k]) |=> $stable(en_q[k]));
    end

    assign en_o = en_q;

endmodule

// File: rtl/irq_pulse_arm.sv
module irq_pulse_arm (
    input  logic clk,
    input  logic rst,
    input  logic any_pend_i,
    input  logic eoi_i,
    output logic pulse_o
);

    logic armed_q;
    logic pulse_q;
    logic fire;

    assign fire = armed_q && any_pend_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
            armed_q <= !fire && (armed_q || eoi_i);
        end
    end

    assign pulse_o = pulse_q;

    assert_pulse_one_wide_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
    assert_pulse_on_pending_R9: assert property (@(posedge clk) disable iff (rst)
        (armed_q && any_pend_i) |=> pulse_o);
    assert_disarmed_after_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> !armed_q);
    assert_stay_disarmed_R10: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !eoi_i) |=> (!pulse_o && !armed_q));

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC  = SRC_COUNT,
    parameter int unsigned N_EN   = EN_COUNT,
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  evt_i,
    output logic              irq_level,
    output logic              irq_pulse
);

    localparam int unsigned N_NOEN = N_SRC - N_EN;

    wr_dec_t          dec;
    logic [N_SRC-1:0] raw;
    logic [N_EN-1:0]  en;
    logic [N_SRC-1:0] en_wide;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] raw_set_v;
    logic [N_SRC-1:0] pend_clr_v;
    logic [N_EN-1:0]  en_set_v;
    logic [N_EN-1:0]  en_clr_v;
    logic             unused_wdata_hi;

    assign dec        = decode_write(reg_wr, reg_addr[REG_ADDR_W-1:0]);
    assign raw_set_v  = dec.raw_set  ? reg_wdata[N_SRC-1:0] : '0;
    assign pend_clr_v = dec.pend_clr ? reg_wdata[N_SRC-1:0] : '0;
    assign en_set_v   = dec.en_set   ? reg_wdata[N_EN-1:0]  : '0;
    assign en_clr_v   = dec.en_clr   ? reg_wdata[N_EN-1:0]  : '0;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:N_SRC];

    irq_raw_bank #(.N_SRC(N_SRC)) i_raw (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .set_i (raw_set_v),
        .clr_i (pend_clr_v),
        .raw_o (raw)
    );

    irq_en_bank #(.N_EN(N_EN)) i_en (
        .clk   (clk),
        .rst   (rst),
        .set_i (en_set_v),
        .clr_i (en_clr_v),
        .en_o  (en)
    );

    if (N_NOEN > 0) begin : g_noen
        assign en_wide = {{N_NOEN{1'b0}}, en};
    end else begin : g_allen
        assign en_wide = en;
    end

    assign pend      = raw & en_wide;
    assign irq_level = |pend;

    irq_pulse_arm i_pulse (
        .clk        (clk),
        .rst        (rst),
        .any_pend_i (irq_level),
        .eoi_i      (dec.eoi),
        .pulse_o    (irq_pulse)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_RAW:                reg_rdata[N_SRC-1:0] = raw;
            SEL_PEND:               reg_rdata[N_SRC-1:0] = pend;
            SEL_EN_SET, SEL_EN_CLR: reg_rdata[N_EN-1:0]  = en;
            default:                reg_rdata = '0;
        endcase
    end

    // A pulse may only start after a cycle in which the level line was high
    assert_pulse_follows_level_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pulse) |-> $past(irq_level));
    // A source without an enable never shows up as pending
    assert_noen_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SEL_PEND) |-> (reg_rdata[N_SRC-1:N_EN] == '0));

endmodule

// File: tb/test_irq_agg_top.sv
module test_irq_agg_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [3:0]  evt_i = 4'd0;
    logic        irq_level;
    logic        irq_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  level;
        logic  pulse;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    logic [3:0] m_raw = 4'd0;
    logic [2:0] m_en = 3'd0;
    logic       m_armed = 1'b1;
    logic       m_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_top i_irq_agg_top (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_i     (evt_i),
        .irq_level (irq_level),
        .irq_pulse (irq_pulse)
    );

    // Monitor: compares line outputs one clock after each driven cycle
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (irq_level !== e.level) begin
                bad++;
                $display("FAIL %s (R8 level): got %0b expected %0b", e.tag, irq_level, e.level);
            end
            total++;
            if (irq_pulse !== e.pulse) begin
                bad++;
                $display("FAIL %s (R9/R10 pulse): got %0b expected %0b", e.tag, irq_pulse, e.pulse);
            end
        end
    end

    // Driver: one clock cycle of stimulus plus the expected line state after it
    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input logic [3:0] e, input string tag);
        logic [3:0] setm, clrm, pend;
        logic [2:0] ens, enc;
        logic eoi, fire;
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = e;
        setm = (wr && a == 3'd0) ? d[3:0] : 4'd0;
        clrm = (wr && a == 3'd1) ? d[3:0] : 4'd0;
        ens  = (wr && a == 3'd2) ? d[2:0] : 3'd0;
        enc  = (wr && a == 3'd3) ? d[2:0] : 3'd0;
        eoi  = wr && (a == 3'd4);
        pend = m_raw & {1'b0, m_en};
        fire = m_armed && (pend != 4'd0);
        m_raw   = (m_raw & ~clrm) | setm | e;
        m_en    = (m_en & ~enc) | ens;
        m_pulse = fire;
        m_armed = !fire && (m_armed || eoi);
        sb_q.push_back('{level: ((m_raw & {1'b0, m_en}) != 4'd0), pulse: m_pulse, tag: tag});
        @(negedge clk);
        reg_wr = 1'b0; evt_i = 4'd0;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 32'd0, 4'd0, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp_v, input string tag);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        total++;
        if (reg_rdata !== exp_v) begin
            bad++;
            $display("FAIL %s read addr %0d: got 0x%0h expected 0x%0h", tag, a, reg_rdata, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 raw");
        rd(3'd2, 32'h0, "R1 enable");
        total++;
        if (irq_level !== 1'b0 || irq_pulse !== 1'b0) begin
            bad++;
            $display("FAIL R1 lines: got %0b%0b expected 00", irq_level, irq_pulse);
        end
        // R2 event with no enable
        step(1'b0, 3'd0, 32'd0, 4'b0001, "R2 key event");
        rd(3'd0, 32'h1, "R2 raw set while disabled");
        rd(3'd1, 32'h0, "R4 pending masked");
        // R7 enable set
        step(1'b1, 3'd2, 32'h2, 4'd0, "R7 set en1");
        rd(3'd2, 32'h2, "R7 read at set addr");
        rd(3'd3, 32'h2, "R7 read at clear addr");
        // R3 software set, R9 pulse
        step(1'b1, 3'd0, 32'h2, 4'd0, "R3 sw set bit1");
        idle("R9 pulse cycle");
        idle("R9 pulse ends");
        rd(3'd0, 32'h3, "R3 raw after sw set");
        rd(3'd1, 32'h2, "R4 pending view");
        step(1'b1, 3'd0, 32'h0, 4'd0, "R3 zero write");
        rd(3'd0, 32'h3, "R3 zero write ignored");
        // R10 no re-pulse without end-of-interrupt
        step(1'b0, 3'd0, 32'd0, 4'b0010, "R10 new event");
        step(1'b1, 3'd2, 32'h1, 4'd0, "R10 enable bit0");
        idle("R10 quiet");
        idle("R10 quiet");
        rd(3'd1, 32'h3, "R4 two pending");
        // R5 clear through pending view
        step(1'b1, 3'd1, 32'h2, 4'd0, "R5 clear bit1");
        rd(3'd0, 32'h1, "R5 raw after clear");
        // R10 end-of-interrupt re-arms
        step(1'b1, 3'd4, 32'h0, 4'd0, "R10 eoi");
        idle("R10 pulse after eoi");
        idle("R10 pulse ends");
        // R6 event wins over clear
        step(1'b1, 3'd1, 32'h1, 4'b0001, "R6 collide");
        rd(3'd0, 32'h1, "R6 bit stays set");
        step(1'b1, 3'd1, 32'h1, 4'd0, "R5 clear bit0");
        rd(3'd0, 32'h0, "R5 raw empty");
        // R5 clearing a bit that is not enabled
        step(1'b0, 3'd0, 32'd0, 4'b0100, "R2 timeout event");
        rd(3'd0, 32'h4, "R2 timeout raw");
        step(1'b1, 3'd1, 32'h4, 4'd0, "R5 clear disabled bit");
        rd(3'd0, 32'h0, "R5 disabled bit cleared");
        // R11 missed event has no enable
        step(1'b0, 3'd0, 32'd0, 4'b1000, "R11 missed event");
        step(1'b1, 3'd2, 32'hF, 4'd0, "R11 enable all");
        idle("R11 lines low");
        rd(3'd2, 32'h7, "R11 enable width");
        rd(3'd1, 32'h0, "R11 pending masked");
        rd(3'd0, 32'h8, "R11 raw bit3");
        // R7 clear address
        step(1'b1, 3'd3, 32'h0, 4'd0, "R7 zero clear");
        rd(3'd3, 32'h7, "R7 zero clear ignored");
        step(1'b1, 3'd3, 32'h1, 4'd0, "R7 clear en0");
        rd(3'd2, 32'h6, "R7 en0 cleared");
        // R9 armed by eoi, then a fresh enabled event
        step(1'b1, 3'd4, 32'h0, 4'd0, "R10 eoi with nothing pending");
        idle("R9 no pending no pulse");
        step(1'b0, 3'd0, 32'd0, 4'b0100, "R9 timeout event");
        idle("R9 pulse");
        step(1'b1, 3'd0, 32'h2, 4'd0, "R10 more pending, disarmed");
        idle("R10 no pulse");
        idle("R10 no pulse");
        rd(3'd1, 32'h6, "R4 pending after set");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule